// File: doc/BRIEF.md
# Clear-to-Send Gated Serial Transmitter

This block serializes bytes onto an asynchronous serial line. Software writes a byte into a one-entry holding register. When the shift stage is free, the byte moves into it and goes out as a frame. The frame has a low start bit, the data bits least significant first, and a high stop bit. Each bit lasts from one bit-rate strobe to the next. A holding-register-empty flag tells software when it may write again.

A clear-to-send pin, active low, is synchronized into the clock domain. Its synchronized level is always visible on an output. Unless a per-block override is set, a negated pin pulls the empty flag to 0, which stops software from supplying more data. The shift stage keeps running either way.

Two control bits can force a line break, which holds the line low for as long as both bits stay set. The line's low time is therefore timed by software. A frame that a break cuts into is not completed on the line. Its remaining bit times stay high, and the next byte starts cleanly at the following frame boundary after the break ends.

Top module: `sertx_top`

## Requirements
- R1: After reset, txLine is 1, tdrEmpty is 1 (with ctsPinN low) and ctsState is 0.
- R2: A frame is one start bit at 0, then the DATA_W data bits least significant bit first, then one stop bit at 1, each held for one bitTick interval; the idle line is 1.
- R3: A write is taken when the holding register is empty, and tdrEmpty reads 0 from the next cycle. The byte moves to the shifter at the first bitTick at which the shifter is idle or is finishing its stop bit, and tdrEmpty then returns to 1.
- R4: A write while the holding register is full is dropped, and no extra frame appears.
- R5: A byte already waiting in the holding register starts its start bit right after the previous stop bit, with no idle gap.
- R6: With ctsIgnore at 0 and the synchronized pin high, tdrEmpty is 0.
- R7: A negated clear-to-send pin does not stall the shifter; an accepted byte is still sent.
- R8: With ctsIgnore at 1, the pin level has no effect on tdrEmpty.
- R9: ctsState shows ctsPinN after SYNC_STAGES clock edges, whatever ctsIgnore is set to.
- R10: While brkEnable and brkSend are both 1, txLine is 0 from the next cycle on, for as long as both stay set.
- R11: brkEnable alone or brkSend alone has no effect on the line.
- R12: During a break, no byte moves from the holding register to the shifter. A frame that the break interrupts shows 1 for its remaining bit times after release, and the waiting byte starts at the next frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | One-cycle strobe marking each bit period |
| wrValid | input | 1 | Write strobe for the holding register |
| wrData | input | DATA_W | Byte to transmit |
| ctsPinN | input | 1 | Clear-to-send pin, low = clear |
| ctsIgnore | input | 1 | 1 = pin does not gate the empty flag |
| brkEnable | input | 1 | Break feature enable |
| brkSend | input | 1 | Break request; the line goes low when this and brkEnable are both 1 |
| txLine | output | 1 | Serial output line |
| tdrEmpty | output | 1 | Holding register empty status, gated by clear-to-send |
| ctsState | output | 1 | Synchronized clear-to-send pin level |

## Verification
A corrupted bit counter or frame register shows up on txLine within one frame, as a shifted or missing stop bit or a mis-ordered data bit. A receiver that samples mid-bit therefore catches it on the first byte. A stuck holding-full flag appears at once on tdrEmpty, or one frame later as a missing or duplicated frame. A spoiled flag that is lost or stuck shows up as stray low bits after a released break, or as a missing byte, before the next frame boundary.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic acceptWr;   // capture wrData into holding register
    logic loadShift;  // copy holding register into frame register
    logic shiftOut;   // advance frame register by one bit
    logic forceLow;   // break override on the line
    logic maskHigh;   // no live frame bit: drive idle level
  } txStrobe_t;

endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitTick,
  input  logic      wrValid,
  input  logic      brkEnable,
  input  logic      brkSend,
  input  logic      ctsIgnore,
  input  logic      ctsSync,
  output txStrobe_t strobe,
  output logic      holdFull,
  output logic      tdrEmpty
);

  localparam int FRAME_BITS = DATA_W + 2;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  logic             active;
  logic             spoiled;
  logic [CNT_W-1:0] bitCnt;
  logic             brkOn;
  logic             lastBit;
  logic             canLoad;
  logic             endFrame;

  assign brkOn    = brkEnable & brkSend;
  assign lastBit  = active && (bitCnt == LAST_IDX);
  // no new frame begins while the line is held in break
  assign canLoad  = bitTick && holdFull && !brkOn && (!active || lastBit);
  assign endFrame = bitTick && lastBit && !canLoad;

  always_comb begin
    strobe.acceptWr  = wrValid && !holdFull;
    strobe.loadShift = canLoad;
    strobe.shiftOut  = bitTick && active && !lastBit;
    strobe.forceLow  = brkOn;
    strobe.maskHigh  = !active || spoiled;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
    end else if (strobe.acceptWr) begin
      holdFull <= 1'b1;
    end else if (canLoad) begin
      holdFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      bitCnt <= '0;
    end else if (canLoad) begin
      active <= 1'b1;
      bitCnt <= '0;
    end else if (endFrame) begin
      active <= 1'b0;
      bitCnt <= '0;
    end else if (bitTick && active) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // a frame touched by a break is never resumed on the line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spoiled <= 1'b0;
    end else if (canLoad || endFrame) begin
      spoiled <= 1'b0;
    end else if (brkOn && active) begin
      spoiled <= 1'b1;
    end
  end

  assign tdrEmpty = !holdFull && (ctsIgnore || !ctsSync);

endmodule

// File: rtl/sertx_dp.sv
module sertx_dp
  import sertx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ctsPinN,
  output logic              ctsSync,
  output logic              txLine
);

  localparam int FRAME_BITS = DATA_W + 2;

  logic [DATA_W-1:0]     holdReg;
  logic [FRAME_BITS-1:0] frameReg;
  logic [SYNC_STAGES-1:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (strobe.acceptWr) begin
      holdReg <= wrData;
    end
  end

  // bit 0 of frameReg is the bit currently on the line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '1;
    end else if (strobe.loadShift) begin
      frameReg <= {1'b1, holdReg, 1'b0};
    end else if (strobe.shiftOut) begin
      frameReg <= {1'b1, frameReg[FRAME_BITS-1:1]};
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= ctsPinN;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], ctsPinN};
      end
    end
  endgenerate

  assign ctsSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txLine <= 1'b1;
    end else if (strobe.forceLow) begin
      txLine <= 1'b0;
    end else if (strobe.maskHigh) begin
      txLine <= 1'b1;
    end else begin
      txLine <= frameReg[0];
    end
  end

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ctsPinN,
  input  logic              ctsIgnore,
  input  logic              brkEnable,
  input  logic              brkSend,
  output logic              txLine,
  output logic              tdrEmpty,
  output logic              ctsState
);

  txStrobe_t strobe;
  logic      ctsSync;
  logic      holdFull;

  sertx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitTick   (bitTick),
    .wrValid   (wrValid),
    .brkEnable (brkEnable),
    .brkSend   (brkSend),
    .ctsIgnore (ctsIgnore),
    .ctsSync   (ctsSync),
    .strobe    (strobe),
    .holdFull  (holdFull),
    .tdrEmpty  (tdrEmpty)
  );

  sertx_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .ctsPinN (ctsPinN),
    .ctsSync (ctsSync),
    .txLine  (txLine)
  );

  assign ctsState = ctsSync;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic wrValid,
  input logic ctsIgnore,
  input logic brkEnable,
  input logic brkSend,
  input logic txLine,
  input logic tdrEmpty,
  input logic ctsState,
  input logic holdFull
);

  p_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && tdrEmpty) |=> !tdrEmpty);

  p_keep_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    (holdFull && !bitTick) |=> holdFull);

  p_cts_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctsIgnore && ctsState) |-> !tdrEmpty);

  p_break_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (brkEnable && brkSend) |=> !txLine);

  p_no_load_brk_r12: assert property (@(posedge clk) disable iff (!rstN)
    (brkEnable && brkSend && holdFull) |=> holdFull);

endmodule

bind sertx_top sertx_chk u_chk (.*);

// File: tb/sertx_top_tb.sv
module sertx_top_tb;

  localparam int TICK_DIV = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic       ctsPinN = 1'b0;
  logic       ctsIgnore = 1'b0;
  logic       brkEnable = 1'b0;
  logic       brkSend = 1'b0;
  logic       txLine;
  logic       tdrEmpty;
  logic       ctsState;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sertx_top u_dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .wrValid(wrValid),
    .wrData(wrData), .ctsPinN(ctsPinN), .ctsIgnore(ctsIgnore),
    .brkEnable(brkEnable), .brkSend(brkSend), .txLine(txLine),
    .tdrEmpty(tdrEmpty), .ctsState(ctsState)
  );

  // stimulus byte and the expected line word, start bit in bit 0
  localparam logic [17:0] VEC [8] = '{
    {8'h00, 10'h200}, {8'hFF, 10'h3FE}, {8'h55, 10'h2AA}, {8'hAA, 10'h354},
    {8'h01, 10'h202}, {8'h80, 10'h300}, {8'h3C, 10'h278}, {8'hC3, 10'h386}
  };

  initial begin
    forever begin
      repeat (TICK_DIV - 1) begin
        @(negedge clk);
        bitTick = 1'b0;
      end
      @(negedge clk);
      bitTick = 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic alignTick();
    @(posedge clk);
    while (bitTick !== 1'b1) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeByte(input logic [7:0] d);
    wrData = d;
    wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  // waits for a start bit, samples mid-bit; gap = cycles waited
  task automatic rxFrame(output logic [9:0] word, output int gap);
    gap = 0;
    while (txLine !== 1'b0 && gap < 2000) begin
      @(negedge clk);
      gap++;
    end
    cyc(TICK_DIV / 2);
    word[0] = txLine;
    for (int i = 1; i < 10; i++) begin
      cyc(TICK_DIV);
      word[i] = txLine;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    logic [9:0] w;
    int gap;
    bit allHigh;

    cyc(5);
    rstN = 1'b1;
    cyc(2);
    // R1 reset state
    check(txLine == 1'b1, "R1 txLine", txLine, 1);
    check(tdrEmpty == 1'b1, "R1 tdrEmpty", tdrEmpty, 1);
    check(ctsState == 1'b0, "R1 ctsState", ctsState, 0);

    // R2 frame table
    for (int k = 0; k < 8; k++) begin
      alignTick();
      writeByte(VEC[k][17:10]);
      rxFrame(w, gap);
      check(w == VEC[k][9:0], "R2 frame", w, VEC[k][9:0]);
      cyc(2 * TICK_DIV);
    end

    // R3 empty flag after write and after transfer
    alignTick();
    writeByte(8'h96);
    check(tdrEmpty == 1'b0, "R3 full after write", tdrEmpty, 0);
    cyc(TICK_DIV + 1);
    check(tdrEmpty == 1'b1, "R3 empty after transfer", tdrEmpty, 1);
    rxFrame(w, gap);
    check(w == 10'h32C, "R3 frame", w, 10'h32C);
    cyc(2 * TICK_DIV);

    // R4 second write while full is dropped
    alignTick();
    writeByte(8'h12);
    writeByte(8'hED);
    rxFrame(w, gap);
    check(w == 10'h224, "R4 first byte", w, 10'h224);
    allHigh = 1'b1;
    for (int i = 0; i < 15 * TICK_DIV; i++) begin
      @(negedge clk);
      if (txLine !== 1'b1) allHigh = 1'b0;
    end
    check(allHigh, "R4 no extra frame", allHigh, 1);

    // R5 back-to-back frames
    alignTick();
    writeByte(8'hA5);
    cyc(TICK_DIV + 2);
    writeByte(8'h5A);
    rxFrame(w, gap);
    check(w == 10'h34A, "R5 first", w, 10'h34A);
    rxFrame(w, gap);
    check(w == 10'h2B4, "R5 second", w, 10'h2B4);
    check(gap <= TICK_DIV / 2 + 1, "R5 no gap", gap, TICK_DIV / 2);
    cyc(2 * TICK_DIV);

    // R6, R7, R9, R8 clear-to-send behaviour
    ctsPinN = 1'b1;
    cyc(4);
    check(ctsState == 1'b1, "R9 pin seen", ctsState, 1);
    check(tdrEmpty == 1'b0, "R6 gated empty", tdrEmpty, 0);
    alignTick();
    writeByte(8'h3C);
    rxFrame(w, gap);
    check(w == 10'h278, "R7 not stalled", w, 10'h278);
    cyc(2 * TICK_DIV);
    ctsIgnore = 1'b1;
    cyc(2);
    check(tdrEmpty == 1'b1, "R8 override", tdrEmpty, 1);
    check(ctsState == 1'b1, "R9 with override", ctsState, 1);
    ctsPinN = 1'b0;
    cyc(4);
    check(ctsState == 1'b0, "R9 pin released", ctsState, 0);
    ctsIgnore = 1'b0;

    // R11 single break bits
    brkSend = 1'b1;
    cyc(3);
    check(txLine == 1'b1, "R11 send only", txLine, 1);
    brkSend = 1'b0;
    brkEnable = 1'b1;
    alignTick();
    writeByte(8'h81);
    rxFrame(w, gap);
    check(w == 10'h302, "R11 enable only frame", w, 10'h302);
    cyc(2 * TICK_DIV);

    // R10 break hold
    brkSend = 1'b1;
    cyc(2);
    check(txLine == 1'b0, "R10 low", txLine, 0);
    cyc(40);
    check(txLine == 1'b0, "R10 held", txLine, 0);
    brkSend = 1'b0;
    cyc(2);
    check(txLine == 1'b1, "R10 released", txLine, 1);

    // R12 no transfer during break
    brkSend = 1'b1;
    writeByte(8'h0F);
    cyc(100);
    check(tdrEmpty == 1'b0, "R12 held during break", tdrEmpty, 0);
    check(txLine == 1'b0, "R12 line low", txLine, 0);
    brkSend = 1'b0;
    rxFrame(w, gap);
    check(w == 10'h21E, "R12 after release", w, 10'h21E);
    cyc(2 * TICK_DIV);

    // R12 interrupted frame is suppressed
    alignTick();
    writeByte(8'h00);
    while (txLine !== 1'b0) @(negedge clk);
    cyc(2 * TICK_DIV);
    writeByte(8'h5A);
    brkSend = 1'b1;
    cyc(3 * TICK_DIV);
    brkSend = 1'b0;
    cyc(2);
    allHigh = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (txLine !== 1'b1) allHigh = 1'b0;
      cyc(TICK_DIV);
    end
    check(allHigh, "R12 remainder high", allHigh, 1);
    rxFrame(w, gap);
    check(w == 10'h2B4, "R12 next byte", w, 10'h2B4);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule